// File: doc/BRIEF.md
# Pulse Accumulator

This block is an 8-bit counter that follows one external input pin. In event mode it adds one for each selected edge of the pin. In gated-time mode the pin acts as a gate, and the counter advances once for every 64 bus clocks during which the pin sits at its active level. An overflow flag reports the wrap from the all-ones count to zero. An edge flag reports each selected edge. Each flag has its own interrupt enable and its own interrupt output.

Software uses a byte-wide register port that decodes four locations. Address 0 is control: bit 0 is the enable, bit 1 selects gated-time mode, and bit 2 selects polarity. Address 1 is the count. Address 2 holds the flags: bit 0 is overflow and bit 1 is edge. Address 3 holds the interrupt enables, with bits placed the same way as the flags. Writes take effect at the clock edge. Reads are combinational, and unused bits read as zero.

Polarity works the same way in both modes. With polarity 0, the selected edge is the falling edge, and in gated-time mode a low level stops the count. With polarity 1, the selected edge is the rising edge, and a high level stops the count. In gated-time mode the selected edge is therefore the edge that ends the counting window. Reset does not touch the count.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the control, flag and interrupt-enable registers read 0x00, and both interrupt outputs are low.
- R2: While control bit 0 (enable) is 0, pin activity never changes the count or sets a flag.
- R3: Event mode with polarity 0 (control 0x01): each falling edge of the pin adds one to the count, and a rising edge adds nothing.
- R4: Event mode with polarity 1 (control 0x05): each rising edge adds one, and a falling edge adds nothing.
- R5: Gated mode with polarity 0 (control 0x03): the count advances once per 64 clocks while the pin is high, and holds while the pin is low. The 64-clock interval restarts each time counting resumes.
- R6: Gated mode with polarity 1 (control 0x07): the count advances once per 64 clocks while the pin is low, and holds while the pin is high.
- R7: In gated mode, the edge flag (bit 1 of address 2) is set by the edge that ends the counting window. The edge that opens the window does not set it.
- R8: When the count steps from 0xFF to 0x00, the overflow flag (bit 0 of address 2) is set.
- R9: Software can read and write the count at any time. Reset leaves the count unchanged. A write that lands in the same cycle as an increment wins.
- R10: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it unchanged.
- R11: Each interrupt output equals its flag ANDed with the matching bit of address 3.
- R12: The pin passes through a two-flop synchronizer. An edge therefore changes the count on the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous accumulator input pin |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for the selected address |
| irqOvf | output | 1 | Overflow interrupt request |
| irqEdge | output | 1 | Edge interrupt request |

## Verification
Suppose the block picked the wrong edge, or confused the gate level. The count read back after a single pin transition would then be off by one, within three clocks of that transition. A prescaler with the wrong length, or one that is not restarted, shifts the gated count by one tick. That error shows up within one 64-clock window, because each check samples mid-window, 32 clocks away from any tick. Flag faults show at once on the interrupt outputs when the enables are set: a flag that fails to set, fails to clear, or is set by the wrong edge. A count cleared by reset shows in the first read after the reset pulse.

// File: rtl/pulse_acc_pkg.sv
package pulse_acc_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_FLAGS = 2'd2,
    REG_MASK  = 2'd3
  } regSel_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_GATED = 1;
  localparam int CTL_POL   = 2;
  localparam int CTL_W     = 3;

  localparam int FLG_OVF  = 0;
  localparam int FLG_EDGE = 1;
  localparam int FLG_W    = 2;

  typedef struct packed {
    logic             incr;
    logic             load;
    logic             edgeHit;
    logic [FLG_W-1:0] flagClr;
  } paStrobe_t;

endpackage

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pulse_acc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [CTL_W-1:0]  wrBits,
  input  logic [DATA_W-1:0] countQ,
  input  logic [FLG_W-1:0]  flagsQ,
  output paStrobe_t         strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOvf,
  output logic              irqEdge
);

  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CTL_W-1:0]       ctrlReg;
  logic [FLG_W-1:0]       maskReg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinNow, pinPrev;
  logic                   activeEdge, inhibited, gateOpen, tick;

  // Register writes for control and interrupt enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_CTRL) ctrlReg <= wrBits;
      if (regAddr == REG_MASK) maskReg <= wrBits[FLG_W-1:0];
    end
  end

  // Synchronizer chain, one flop per stage
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= pulseIn;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[g] <= 1'b0;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinNow;
  end

  // Polarity picks the counted edge and, in gated mode, the blocking level.
  // The selected edge always closes the gated window.
  assign activeEdge = ctrlReg[CTL_POL] ? (pinNow & ~pinPrev) : (~pinNow & pinPrev);
  assign inhibited  = ctrlReg[CTL_POL] ? pinNow : ~pinNow;
  assign gateOpen   = ctrlReg[CTL_EN] & ctrlReg[CTL_GATED] & ~inhibited;

  if (DIV > 1) begin : g_pre
    logic [PRE_W-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (!rstN || !gateOpen)              preCnt <= '0;
      else if (preCnt == PRE_W'(DIV - 1))  preCnt <= '0;
      else                                 preCnt <= preCnt + 1'b1;
    end
    assign tick = gateOpen && (preCnt == PRE_W'(DIV - 1));
  end else begin : g_nopre
    assign tick = gateOpen;
  end

  always_comb begin
    strobe.incr    = ctrlReg[CTL_EN] & (ctrlReg[CTL_GATED] ? tick : activeEdge);
    strobe.edgeHit = ctrlReg[CTL_EN] & activeEdge;
    strobe.load    = regWrEn && (regAddr == REG_COUNT);
    strobe.flagClr = (regWrEn && (regAddr == REG_FLAGS)) ? wrBits[FLG_W-1:0] : '0;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL:  regRdData[CTL_W-1:0] = ctrlReg;
      REG_COUNT: regRdData            = countQ;
      REG_FLAGS: regRdData[FLG_W-1:0] = flagsQ;
      default:   regRdData[FLG_W-1:0] = maskReg;
    endcase
  end

  assign irqOvf  = flagsQ[FLG_OVF]  & maskReg[FLG_OVF];
  assign irqEdge = flagsQ[FLG_EDGE] & maskReg[FLG_EDGE];

  // R2: a disabled accumulator issues no count or edge strobe
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CTL_EN] |-> !(strobe.incr || strobe.edgeHit));

  // R5: gated increments never fall in back-to-back cycles
  a_r5_gated_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && ctrlReg[CTL_GATED] && (DIV > 1)) |=> !strobe.incr);

endmodule

// File: rtl/pacc_datapath.sv
module pacc_datapath
  import pulse_acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  paStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countQ,
  output logic [FLG_W-1:0]  flagsQ
);

  logic             wrapHit;
  logic [FLG_W-1:0] flagSet;

  // Counter deliberately has no reset
  always_ff @(posedge clk) begin
    if (strobe.load)      countQ <= loadVal;
    else if (strobe.incr) countQ <= countQ + 1'b1;
  end

  assign wrapHit = strobe.incr && !strobe.load && (countQ == '1);

  always_comb begin
    flagSet           = '0;
    flagSet[FLG_OVF]  = wrapHit;
    flagSet[FLG_EDGE] = strobe.edgeHit;
  end

  // Set wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagSet | (flagsQ & ~strobe.flagClr);
  end

  // R3: an increment with no load advances the count by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.load && (countQ != '1)) |=> (countQ == DATA_W'($past(countQ) + 1'b1)));

  // R8: stepping past all ones sets the overflow flag
  a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.load && (countQ == '1)) |=> (flagsQ[FLG_OVF] && (countQ == '0)));

  // R9: a software write takes priority
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (countQ == $past(loadVal)));

  // R10: a cleared edge flag stays clear unless a new edge arrives
  a_r10_clear_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagClr[FLG_EDGE] && !strobe.edgeHit) |=> !flagsQ[FLG_EDGE]);

  // R7: a detected selected edge sets the edge flag
  a_r7_edge_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.edgeHit |=> flagsQ[FLG_EDGE]);

endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pulse_acc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOvf,
  output logic              irqEdge
);

  paStrobe_t         strobe;
  logic [DATA_W-1:0] countQ;
  logic [FLG_W-1:0]  flagsQ;

  pacc_ctrl #(
    .DATA_W      (DATA_W),
    .DIV         (DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .wrBits    (regWrData[CTL_W-1:0]),
    .countQ    (countQ),
    .flagsQ    (flagsQ),
    .strobe    (strobe),
    .regRdData (regRdData),
    .irqOvf    (irqOvf),
    .irqEdge   (irqEdge)
  );

  pacc_datapath #(
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (regWrData),
    .countQ  (countQ),
    .flagsQ  (flagsQ)
  );

endmodule

// File: tb/test_pulse_acc.sv
module test_pulse_acc;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irqOvf, irqEdge;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_acc i_pulse_acc (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOvf(irqOvf), .irqEdge(irqEdge)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pinTo(input logic v);
    @(negedge clk);
    pulseIn = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic expectReg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    readReg(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    expectReg("R1 ctrl", 2'd0, 8'h00);
    expectReg("R1 flags", 2'd2, 8'h00);
    expectReg("R1 mask", 2'd3, 8'h00);
    check("R1 irqs", {6'd0, irqOvf, irqEdge}, 8'h00);
  endtask

  task automatic t_persist();
    writeReg(2'd1, 8'h5A);
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    expectReg("R9 count kept over reset", 2'd1, 8'h5A);
  endtask

  task automatic t_disabled();
    for (int i = 0; i < 3; i++) begin
      pinTo(1'b1);
      pinTo(1'b0);
    end
    expectReg("R2 count frozen", 2'd1, 8'h5A);
    expectReg("R2 no flags", 2'd2, 8'h00);
  endtask

  task automatic t_falling();
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'h01);
    pinTo(1'b1);
    expectReg("R3 rise ignored", 2'd1, 8'h00);
    expectReg("R3 no flag on rise", 2'd2, 8'h00);
    pinTo(1'b0);
    expectReg("R3 fall counted", 2'd1, 8'h01);
    expectReg("R3 edge flag", 2'd2, 8'h02);
    for (int i = 0; i < 2; i++) begin
      pinTo(1'b1);
      pinTo(1'b0);
    end
    expectReg("R3 three falls", 2'd1, 8'h03);
  endtask

  task automatic t_rising();
    writeReg(2'd0, 8'h05);
    writeReg(2'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      pinTo(1'b1);
      pinTo(1'b0);
    end
    expectReg("R4 four rises", 2'd1, 8'h04);
    pinTo(1'b1);
    expectReg("R4 rise counted", 2'd1, 8'h05);
    pinTo(1'b0);
    expectReg("R4 fall ignored", 2'd1, 8'h05);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    writeReg(2'd1, 8'h00);
    regAddr = 2'd1;
    @(negedge clk) pulseIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) d = regRdData;
    check("R12 unchanged after two edges", d, 8'h00);
    @(posedge clk);
    @(negedge clk) d = regRdData;
    check("R12 counted on third edge", d, 8'h01);
    pinTo(1'b0);
  endtask

  task automatic t_load_priority();
    writeReg(2'd1, 8'h10);
    writeReg(2'd2, 8'h03);
    @(negedge clk) pulseIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = 2'd1; regWrData = 8'h40; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
    expectReg("R9 write beats increment", 2'd1, 8'h40);
    expectReg("R9 edge still flagged", 2'd2, 8'h02);
    pinTo(1'b0);
  endtask

  task automatic t_gated_high();
    writeReg(2'd0, 8'h00);
    pinTo(1'b1);
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h03);
    writeReg(2'd0, 8'h03);
    repeat (64 * 3 + 32) @(posedge clk);
    expectReg("R5 three ticks while high", 2'd1, 8'h03);
    pinTo(1'b0);
    repeat (200) @(posedge clk);
    expectReg("R5 low holds count", 2'd1, 8'h03);
    expectReg("R7 trailing fall flags", 2'd2, 8'h02);
    writeReg(2'd2, 8'h03);
    pinTo(1'b1);
    expectReg("R7 leading rise no flag", 2'd2, 8'h00);
    repeat (64 + 28) @(posedge clk);
    expectReg("R5 interval restarts", 2'd1, 8'h04);
  endtask

  task automatic t_gated_low();
    writeReg(2'd0, 8'h07);
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h03);
    repeat (200) @(posedge clk);
    expectReg("R6 high holds count", 2'd1, 8'h00);
    pinTo(1'b0);
    expectReg("R7 leading fall no flag", 2'd2, 8'h00);
    repeat (64 * 2 + 28) @(posedge clk);
    expectReg("R6 two ticks while low", 2'd1, 8'h02);
    pinTo(1'b1);
    expectReg("R7 trailing rise flags", 2'd2, 8'h02);
    expectReg("R6 count after close", 2'd1, 8'h02);
  endtask

  task automatic t_overflow();
    writeReg(2'd0, 8'h00);
    pinTo(1'b0);
    writeReg(2'd1, 8'hFE);
    writeReg(2'd2, 8'h03);
    writeReg(2'd0, 8'h01);
    pinTo(1'b1);
    pinTo(1'b0);
    expectReg("R8 reach FF", 2'd1, 8'hFF);
    expectReg("R8 no overflow yet", 2'd2, 8'h02);
    pinTo(1'b1);
    pinTo(1'b0);
    expectReg("R8 wrap to zero", 2'd1, 8'h00);
    expectReg("R8 overflow flag", 2'd2, 8'h03);
  endtask

  task automatic t_irq_and_clear();
    check("R11 masked irqs", {6'd0, irqOvf, irqEdge}, 8'h00);
    writeReg(2'd3, 8'h01);
    #2 check("R11 overflow irq only", {6'd0, irqOvf, irqEdge}, 8'h02);
    writeReg(2'd3, 8'h02);
    #2 check("R11 edge irq only", {6'd0, irqOvf, irqEdge}, 8'h01);
    writeReg(2'd3, 8'h03);
    writeReg(2'd2, 8'h00);
    expectReg("R10 zero write keeps flags", 2'd2, 8'h03);
    writeReg(2'd2, 8'h01);
    expectReg("R10 clear overflow", 2'd2, 8'h02);
    check("R11 irq follows clear", {6'd0, irqOvf, irqEdge}, 8'h01);
    writeReg(2'd2, 8'h02);
    expectReg("R10 clear edge", 2'd2, 8'h00);
    check("R11 irqs low", {6'd0, irqOvf, irqEdge}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_persist();
    t_disabled();
    t_falling();
    t_rising();
    t_latency();
    t_load_priority();
    t_gated_high();
    t_gated_low();
    t_overflow();
    t_irq_and_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule